// File: doc/BRIEF.md
# Double-Precision NaN Classifier and Quieter

This unit inspects one 64-bit IEEE 754 binary64 operand per cycle and reports what kind of value it holds. The kinds are zero, subnormal, normal, infinity, quiet NaN and signaling NaN, and the class is given as a one-hot code. It also gives a separate signaling-NaN flag. When the caller raises the quieting request and the operand is a signaling NaN, the unit returns the quieted NaN and raises an invalid-operation flag. A mode input chooses the NaN encoding. In the modern encoding, a set top fraction bit marks a quiet NaN. In the legacy encoding the meaning of that bit is inverted.

Operands are accepted with a valid strobe. Every result is registered and appears one clock after the operand it belongs to. While the strobe is low, the last result is held. A quieting request on an operand that is not a signaling NaN is a caller error. The unit does not quiet that operand: it passes it through unchanged and leaves the invalid flag low.

Top module: `dp_nan_unit`

## Requirements
- R1: `class_out` is one-hot, with bit 0 for zero, bit 1 for subnormal, bit 2 for normal, bit 3 for infinity, bit 4 for quiet NaN and bit 5 for signaling NaN. Zero means exponent field 0 and fraction 0. Subnormal means exponent 0 and a nonzero fraction. Infinity means exponent 0x7FF and fraction 0. Any other exponent is normal.
- R2: When the exponent is 0x7FF and the fraction is nonzero, the operand is a NaN. It is signaling when fraction bit 51 equals `legacy_mode` (0 selects the modern encoding, 1 the legacy one) and quiet otherwise.
- R3: `is_snan` is high exactly when the operand is a signaling NaN under the selected mode.
- R4: In modern mode, quieting a signaling NaN sets fraction bit 51 and leaves every other bit, the sign included, unchanged.
- R5: In legacy mode, quieting a signaling NaN clears fraction bit 51 and leaves the other bits unchanged, unless R6 applies.
- R6: In legacy mode, if clearing bit 51 would leave a zero fraction, fraction bit 50 is set so that the result is still a NaN.
- R7: `invalid_flag` is high exactly when `quiet_req` was high and the operand was a signaling NaN.
- R8: In every case that does not quiet, `result` equals the operand bit for bit. This covers `quiet_req` low, and `quiet_req` high on an operand that is not a signaling NaN.
- R9: Outputs are registered. The result for an operand taken with `in_valid` high appears on the next cycle with `out_valid` high. With `in_valid` low, `out_valid` falls and the data outputs hold. Synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 64 | binary64 operand |
| legacy_mode | input | 1 | 0 selects the modern NaN encoding, 1 the inverted legacy encoding |
| quiet_req | input | 1 | Request to quiet a signaling NaN |
| out_valid | output | 1 | Registered results are new this cycle |
| class_out | output | 6 | One-hot class code |
| is_snan | output | 1 | Operand was a signaling NaN |
| result | output | 64 | Quieted NaN or operand passed through |
| invalid_flag | output | 1 | Invalid-operation flag raised by quieting |

## Verification
The sharpest case is a legacy signaling NaN whose only set fraction bit is bit 51. A design without the fallback would turn it into infinity, and one that picked the wrong fallback bit would produce a different NaN. The same NaN bit patterns are run under both modes. A design that inverted the discriminator would swap the quiet and signaling classes and quiet the wrong values. Quieting requests on normals, infinities and quiet NaNs catch a design that alters non-signaling operands or raises the invalid flag spuriously. Negative-signed NaNs and idle cycles catch sign corruption and a failure to hold the outputs.

// File: rtl/dp_nan_pkg.sv
package dp_nan_pkg;
  localparam int CLS_ZERO   = 0;
  localparam int CLS_DENORM = 1;
  localparam int CLS_NORMAL = 2;
  localparam int CLS_INF    = 3;
  localparam int CLS_QNAN   = 4;
  localparam int CLS_SNAN   = 5;
  localparam int CLS_W      = 6;
endpackage

// File: rtl/dp_field_classifier.sv
module dp_field_classifier
  import dp_nan_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic                  legacy_mode,
  output logic [CLS_W-1:0]      cls,
  output logic                  snan
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_zero, exp_ones, frac_zero, nan, sig_sense;

  assign expo      = operand[EXP_W+FRAC_W-1:FRAC_W];
  assign frac      = operand[FRAC_W-1:0];
  assign exp_zero  = (expo == '0);
  assign exp_ones  = (expo == '1);
  assign frac_zero = (frac == '0);
  assign nan       = exp_ones && !frac_zero;
  // Signaling when the top fraction bit agrees with the mode bit.
  assign sig_sense = ~(frac[FRAC_W-1] ^ legacy_mode);
  assign snan      = nan && sig_sense;

  always_comb begin
    cls             = '0;
    cls[CLS_ZERO]   = exp_zero && frac_zero;
    cls[CLS_DENORM] = exp_zero && !frac_zero;
    cls[CLS_NORMAL] = !exp_zero && !exp_ones;
    cls[CLS_INF]    = exp_ones && frac_zero;
    cls[CLS_QNAN]   = nan && !sig_sense;
    cls[CLS_SNAN]   = nan && sig_sense;
  end
endmodule

// File: rtl/dp_nan_quieter.sv
module dp_nan_quieter #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic                  legacy_mode,
  output logic [EXP_W+FRAC_W:0] quieted
);
  localparam logic [FRAC_W-1:0] TOP_BIT  = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] NEXT_BIT = {2'b01, {(FRAC_W-2){1'b0}}};

  logic [FRAC_W-1:0] frac_in, frac_cleared, frac_out;

  assign frac_in      = operand[FRAC_W-1:0];
  assign frac_cleared = frac_in & ~TOP_BIT;

  always_comb begin
    if (!legacy_mode)
      frac_out = frac_in | TOP_BIT;
    else if (frac_cleared == '0)
      frac_out = NEXT_BIT;   // keep it a NaN rather than infinity
    else
      frac_out = frac_cleared;
  end

  assign quieted = {operand[EXP_W+FRAC_W:FRAC_W], frac_out};
endmodule

// File: rtl/dp_nan_unit.sv
module dp_nan_unit
  import dp_nan_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     operand,
  input  logic             legacy_mode,
  input  logic             quiet_req,
  output logic             out_valid,
  output logic [CLS_W-1:0] class_out,
  output logic             is_snan,
  output logic [W-1:0]     result,
  output logic             invalid_flag
);
  logic [CLS_W-1:0] cls_c;
  logic             snan_c;
  logic [W-1:0]     quieted_c;
  logic             do_quiet;

  dp_field_classifier #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
    .operand(operand), .legacy_mode(legacy_mode), .cls(cls_c), .snan(snan_c)
  );

  dp_nan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .operand(operand), .legacy_mode(legacy_mode), .quieted(quieted_c)
  );

  assign do_quiet = quiet_req && snan_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      class_out    <= '0;
      is_snan      <= 1'b0;
      result       <= '0;
      invalid_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        class_out    <= cls_c;
        is_snan      <= snan_c;
        result       <= do_quiet ? quieted_c : operand;
        invalid_flag <= do_quiet;
      end
    end
  end

  assert_class_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(class_out) == 1);

  assert_snan_agrees_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> is_snan == class_out[CLS_SNAN]);

  assert_quiet_bit_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && invalid_flag |-> result[FRAC_W-1] == !$past(legacy_mode));

  assert_stays_nan_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && invalid_flag |->
      (result[W-2:FRAC_W] == '1) && (result[FRAC_W-1:0] != '0));

  assert_invalid_needs_snan_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && invalid_flag |-> is_snan && $past(quiet_req));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !invalid_flag |-> result == $past(operand));

  assert_sign_kept_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result[W-1] == $past(operand[W-1]));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result) && $stable(class_out));
endmodule

// File: tb/test_dp_nan_unit.sv
module test_dp_nan_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic        legacy_mode = 1'b0;
  logic        quiet_req = 1'b0;
  logic        out_valid;
  logic [5:0]  class_out;
  logic        is_snan;
  logic [63:0] result;
  logic        invalid_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        e_valid = 0;
  logic [5:0]  e_class = '0;
  logic        e_snan = 0;
  logic [63:0] e_result = '0;
  logic        e_inv = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #5 clk = ~clk;

  dp_nan_unit i_dp_nan_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .legacy_mode(legacy_mode), .quiet_req(quiet_req), .out_valid(out_valid),
    .class_out(class_out), .is_snan(is_snan), .result(result),
    .invalid_flag(invalid_flag)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer decode of fields, then the rules.
  task automatic model(logic [63:0] x, logic mode, logic q);
    int e = int'(x[62:52]);
    logic [51:0] f = x[51:0];
    bit is_nan = (e == 2047) && (f != 0);
    bit sig = is_nan && ((mode == 1'b0) ? (f[51] == 1'b0) : (f[51] == 1'b1));
    logic [63:0] r = x;
    e_class = '0;
    if (e == 0 && f == 0) e_class[0] = 1;
    else if (e == 0) e_class[1] = 1;
    else if (e != 2047) e_class[2] = 1;
    else if (f == 0) e_class[3] = 1;
    else if (sig) e_class[5] = 1;
    else e_class[4] = 1;
    e_snan = sig;
    e_inv = q && sig;
    if (q && sig) begin
      if (mode == 1'b0) r[51] = 1'b1;
      else begin
        r[51] = 1'b0;
        if (r[51:0] == 0) r[50] = 1'b1;
      end
    end
    e_result = r;
  endtask

  task automatic step(string tag, logic [63:0] x, logic mode, logic q, logic v);
    operand = x; legacy_mode = mode; quiet_req = q; in_valid = v;
    @(negedge clk);
    e_valid = v;
    if (v) model(x, mode, q);
    chk({tag, " R9 out_valid"}, 64'(out_valid), 64'(e_valid));
    chk({tag, " R1 R2 class"}, 64'(class_out), 64'(e_class));
    chk({tag, " R3 is_snan"}, 64'(is_snan), 64'(e_snan));
    chk({tag, " R4 R5 R6 R8 result"}, result, e_result);
    chk({tag, " R7 invalid"}, 64'(invalid_flag), 64'(e_inv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 reset valid", 64'(out_valid), 64'd0);
    chk("R9 reset class", 64'(class_out), 64'd0);
    chk("R9 reset result", result, 64'd0);
    chk("R9 reset invalid", 64'(invalid_flag), 64'd0);

    step("R1 +zero", 64'h0000000000000000, 0, 0, 1);
    step("R1 -zero", 64'h8000000000000000, 1, 1, 1);
    step("R1 subnormal", 64'h000FFFFFFFFFFFFF, 0, 0, 1);
    step("R1 normal", 64'h3FF0000000000000, 0, 1, 1);
    step("R1 +inf", 64'h7FF0000000000000, 0, 1, 1);
    step("R1 -inf", 64'hFFF0000000000000, 1, 1, 1);
    step("R2 qnan modern", 64'h7FF8000000000000, 0, 1, 1);
    step("R2 snan legacy", 64'h7FF8000000000000, 1, 0, 1);
    step("R4 quiet modern", 64'h7FF0000000000001, 0, 1, 1);
    step("R4 quiet modern neg", 64'hFFF4000000000ABC, 0, 1, 1);
    step("R6 legacy fallback", 64'h7FF8000000000000, 1, 1, 1);
    step("R6 legacy fallback neg", 64'hFFF8000000000000, 1, 1, 1);
    step("R5 legacy clear", 64'hFFF8000000000123, 1, 1, 1);
    step("R8 legacy qnan req", 64'h7FF0000000000001, 1, 1, 1);
    step("R8 snan no req", 64'h7FF0000000000001, 0, 0, 1);
    step("R9 idle hold", 64'h123456789ABCDEF0, 1, 1, 0);
    step("R9 idle hold2", 64'h7FF0000000000001, 0, 1, 0);
    step("R1 max normal", 64'h7FEFFFFFFFFFFFFF, 0, 1, 1);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] x;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      x = rng;
      case (rng[1:0])
        2'd0: x[62:52] = 11'h7FF;
        2'd1: x[62:52] = 11'h000;
        default: ;
      endcase
      if (rng[7:5] == 3'd0) x[50:0] = '0;
      if (rng[9:8] == 2'd0) x[51:0] = '0;
      step("R2 R7 sweep", x, rng[10], rng[11], rng[14:12] != 3'd0);
    end

    done = 1;
    report();
  end
endmodule